// File: doc/BRIEF.md
# Column Clock and Set/Reset Selector

This block selects clock and set/reset signals for a logic array that is built as columns. Each column is split into sectors of a fixed number of cells. Clock selection happens in two levels. First, one column multiplexer picks a clock from a pool of global clocks. The leftmost and rightmost columns can instead pick one of their own pair of fast clocks. Second, every sector picks either that column clock or a clock from a local routing line. The sector then passes that clock through unchanged, passes it inverted, or ties it low. Tying a sector clock low stops all activity in sectors that hold no registers.

Each sector also has a set/reset multiplexer. It chooses between the single global set/reset line and a local set/reset line. It can invert the chosen signal. It then steers the result to either the set input or the reset input of the sector's registers. These paths are asynchronous and active-low.

All selections are configuration bits, held in registers clocked by `cfg_clk` and captured on a load strobe. Until configuration is declared complete, the outputs are forced to safe values: every sector clock is held at 0 and every register is held set. The multiplexers are purely combinational, so a change on a selected clock or set/reset line reaches the outputs in the same cycle.

Top module: `colclk_sel_top`

## Requirements
- R1: While unconfigured (after `cfg_rst_n` low, before `cfg_done` has been sampled high), every `sect_clk` bit is 0, every `sect_set_n` bit is 0 and every `sect_rst_n` bit is 1, whatever the other inputs are.
- R2: A 4-bit column select code k in 0..7 (field `cfg_col_sel[4c+3:4c]` for column c) routes `gclk[k]` as the column clock.
- R3: In column 0, codes 8 and 9 select `fclk[0]` and `fclk[1]`. In column NCOLS-1, codes 8 and 9 select `fclk[2]` and `fclk[3]`.
- R4: In interior columns, codes 8..15 give a column clock of 0. In the edge columns, codes 10..15 give 0.
- R5: Sector i = c*NSECT+s takes its clock from the column clock of column c when `cfg_sclk_src[i]`=0, and from `loc_clk[i]` when it is 1.
- R6: The sector clock polarity field `cfg_sclk_pol[2i+1:2i]` works as follows: 01 passes the selected clock unchanged, 10 inverts it, and 00 or 11 ties `sect_clk[i]` to 0.
- R7: The sector set/reset source is `gsr_n` when `cfg_sr_src[i]`=0 and `loc_sr_n[i]` when it is 1.
- R8: With `cfg_sr_inv[i]`=0 the chosen set/reset line passes unchanged (active-low). With `cfg_sr_inv[i]`=1 it is inverted.
- R9: With `cfg_sr_set[i]`=0 the effective signal drives `sect_rst_n[i]` and `sect_set_n[i]` is 1. With `cfg_sr_set[i]`=1 it drives `sect_set_n[i]` and `sect_rst_n[i]` is 1.
- R10: Configuration fields are captured only on a rising `cfg_clk` edge with `cfg_we`=1. Changing the `cfg_*` field inputs while `cfg_we`=0 leaves the outputs unchanged.
- R11: The configured state starts on the first rising `cfg_clk` edge with `cfg_done`=1. It stays until `cfg_rst_n` goes low, even if `cfg_done` drops. Reset also clears every configuration field to 0.
- R12: Once configured, a change on a selected clock or set/reset input reaches the sector outputs with no `cfg_clk` edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_clk | input | 1 | Configuration register clock |
| cfg_rst_n | input | 1 | Asynchronous active-low reset of the configuration state |
| cfg_we | input | 1 | Capture strobe for all configuration fields |
| cfg_done | input | 1 | Marks configuration complete |
| cfg_col_sel | input | 4*NCOLS | Column clock select code, 4 bits per column |
| cfg_sclk_src | input | NCOLS*NSECT | Sector clock source: 0 column, 1 local |
| cfg_sclk_pol | input | 2*NCOLS*NSECT | Sector clock polarity field, 2 bits per sector |
| cfg_sr_src | input | NCOLS*NSECT | Sector set/reset source: 0 global, 1 local |
| cfg_sr_inv | input | NCOLS*NSECT | Sector set/reset inversion |
| cfg_sr_set | input | NCOLS*NSECT | Steer set/reset to set (1) or reset (0) |
| gclk | input | NGCLK | Global clocks |
| fclk | input | 2*NFCLK | Fast clocks: low pair for column 0, high pair for the last column |
| loc_clk | input | NCOLS*NSECT | Local routing clock per sector |
| gsr_n | input | 1 | Global set/reset, active low |
| loc_sr_n | input | NCOLS*NSECT | Local set/reset per sector, active low |
| sect_clk | output | NCOLS*NSECT | Clock delivered to each sector |
| sect_set_n | output | NCOLS*NSECT | Active-low set to each sector's registers |
| sect_rst_n | output | NCOLS*NSECT | Active-low reset to each sector's registers |

## Verification
The column multiplexers are swept over all sixteen codes. Two source patterns are used: a single high source among lows, and a single low source among highs. Together these show whether a column picks exactly the intended clock, and whether an out-of-range code gives a true 0 rather than a neighbouring line. Mixed per-column codes expose any mix-up of which column reads which select field, and whether the left and right fast pairs are swapped. Every combination of sector source and polarity is tried with both levels of the column and local lines. Every combination of set/reset source, inversion and steering is tried with both levels of the global and local lines. The local lines alternate between sectors, so a wrong sector index shows up. A final pass with different configurations per sector covers both the configuration-capture rules and the unconfigured forcing, including forcing again after a later reset.

// File: rtl/colclk_sel_pkg.sv
package colclk_sel_pkg;

  localparam int COL_SEL_W = 4;

  typedef enum logic [1:0] {
    SPOL_OFF  = 2'b00,
    SPOL_TRUE = 2'b01,
    SPOL_INV  = 2'b10,
    SPOL_OFF3 = 2'b11
  } sclk_pol_e;

  typedef struct packed {
    logic      sclk_src;
    sclk_pol_e sclk_pol;
    logic      sr_src;
    logic      sr_inv;
    logic      sr_set;
  } sect_cfg_t;

  typedef enum logic [1:0] {
    EDGE_NONE  = 2'd0,
    EDGE_LEFT  = 2'd1,
    EDGE_RIGHT = 2'd2
  } col_edge_e;

endpackage

// File: rtl/colclk_cfg_bank.sv
module colclk_cfg_bank
  import colclk_sel_pkg::*;
#(
  parameter int NCOLS = 4,
  parameter int NSECT = 2,
  localparam int NS = NCOLS * NSECT
) (
  input  logic                           cfg_clk,
  input  logic                           cfg_rst_n,
  input  logic                           cfg_we,
  input  logic                           cfg_done,
  input  logic [NCOLS*COL_SEL_W-1:0]     cfg_col_sel,
  input  logic [NS-1:0]                  cfg_sclk_src,
  input  logic [2*NS-1:0]                cfg_sclk_pol,
  input  logic [NS-1:0]                  cfg_sr_src,
  input  logic [NS-1:0]                  cfg_sr_inv,
  input  logic [NS-1:0]                  cfg_sr_set,
  output logic [NCOLS-1:0][COL_SEL_W-1:0] col_q,
  output sect_cfg_t [NS-1:0]             sect_q,
  output logic                           cfgd_q
);

  sect_cfg_t [NS-1:0] sect_d;

  for (genvar i = 0; i < NS; i++) begin : g_pack
    assign sect_d[i].sclk_src = cfg_sclk_src[i];
    assign sect_d[i].sclk_pol = sclk_pol_e'(cfg_sclk_pol[2*i +: 2]);
    assign sect_d[i].sr_src   = cfg_sr_src[i];
    assign sect_d[i].sr_inv   = cfg_sr_inv[i];
    assign sect_d[i].sr_set   = cfg_sr_set[i];
  end

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      col_q  <= '0;
      sect_q <= '0;
    end else if (cfg_we) begin
      for (int c = 0; c < NCOLS; c++) begin
        col_q[c] <= cfg_col_sel[c*COL_SEL_W +: COL_SEL_W];
      end
      sect_q <= sect_d;
    end
  end

  always_ff @(posedge cfg_clk or negedge cfg_rst_n) begin
    if (!cfg_rst_n) begin
      cfgd_q <= 1'b0;
    end else if (cfg_done) begin
      cfgd_q <= 1'b1;
    end
  end

  // R10
  cfg_hold_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !cfg_we |=> ($stable(col_q) && $stable(sect_q)));

  // R11
  cfgd_sticky_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    cfgd_q |=> cfgd_q);

  // R11
  cfgd_rise_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    $rose(cfgd_q) |-> $past(cfg_done));

endmodule

// File: rtl/colclk_col_mux.sv
module colclk_col_mux
  import colclk_sel_pkg::*;
#(
  parameter int        NGCLK = 8,
  parameter int        NFCLK = 2,
  parameter col_edge_e EDGE  = EDGE_NONE
) (
  input  logic [NGCLK-1:0]     gclk,
  input  logic [NFCLK-1:0]     fclk_edge,
  input  logic [COL_SEL_W-1:0] sel,
  output logic                 col_clk
);

  logic g_hit;
  logic f_hit;

  always_comb begin
    g_hit = 1'b0;
    for (int k = 0; k < NGCLK; k++) begin
      if (sel == COL_SEL_W'(k)) g_hit = gclk[k];
    end
  end

  if (EDGE != EDGE_NONE) begin : g_edge
    always_comb begin
      f_hit = 1'b0;
      for (int k = 0; k < NFCLK; k++) begin
        if (sel == COL_SEL_W'(NGCLK + k)) f_hit = fclk_edge[k];
      end
    end
  end else begin : g_inner
    logic unused_fclk;
    assign unused_fclk = ^fclk_edge;
    assign f_hit = 1'b0;
  end

  assign col_clk = g_hit | f_hit;

endmodule

// File: rtl/colclk_sect_clk.sv
module colclk_sect_clk
  import colclk_sel_pkg::*;
(
  input  logic      col_clk,
  input  logic      loc_clk,
  input  logic      src_loc,
  input  sclk_pol_e pol,
  input  logic      cfgd,
  output logic      sect_clk
);

  logic picked;
  logic shaped;

  assign picked = src_loc ? loc_clk : col_clk;

  always_comb begin
    unique case (pol)
      SPOL_TRUE: shaped = picked;
      SPOL_INV:  shaped = ~picked;
      default:   shaped = 1'b0;
    endcase
  end

  assign sect_clk = cfgd & shaped;

endmodule

// File: rtl/colclk_sect_sr.sv
module colclk_sect_sr (
  input  logic gsr_n,
  input  logic loc_sr_n,
  input  logic src_loc,
  input  logic inv,
  input  logic to_set,
  input  logic cfgd,
  output logic set_n,
  output logic rst_n
);

  logic eff_n;

  assign eff_n = (src_loc ? loc_sr_n : gsr_n) ^ inv;

  always_comb begin
    if (!cfgd) begin
      set_n = 1'b0;
      rst_n = 1'b1;
    end else if (to_set) begin
      set_n = eff_n;
      rst_n = 1'b1;
    end else begin
      set_n = 1'b1;
      rst_n = eff_n;
    end
  end

endmodule

// File: rtl/colclk_sel_top.sv
module colclk_sel_top
  import colclk_sel_pkg::*;
#(
  parameter int NCOLS = 4,
  parameter int NSECT = 2,
  parameter int NGCLK = 8,
  parameter int NFCLK = 2,
  localparam int NS = NCOLS * NSECT
) (
  input  logic                       cfg_clk,
  input  logic                       cfg_rst_n,
  input  logic                       cfg_we,
  input  logic                       cfg_done,
  input  logic [NCOLS*COL_SEL_W-1:0] cfg_col_sel,
  input  logic [NS-1:0]              cfg_sclk_src,
  input  logic [2*NS-1:0]            cfg_sclk_pol,
  input  logic [NS-1:0]              cfg_sr_src,
  input  logic [NS-1:0]              cfg_sr_inv,
  input  logic [NS-1:0]              cfg_sr_set,
  input  logic [NGCLK-1:0]           gclk,
  input  logic [2*NFCLK-1:0]         fclk,
  input  logic [NS-1:0]              loc_clk,
  input  logic                       gsr_n,
  input  logic [NS-1:0]              loc_sr_n,
  output logic [NS-1:0]              sect_clk,
  output logic [NS-1:0]              sect_set_n,
  output logic [NS-1:0]              sect_rst_n
);

  logic [NCOLS-1:0][COL_SEL_W-1:0] col_q;
  sect_cfg_t [NS-1:0]              sect_q;
  logic                            cfgd_q;
  logic [NCOLS-1:0]                col_clk;

  colclk_cfg_bank #(.NCOLS(NCOLS), .NSECT(NSECT)) u_cfg (
    .cfg_clk      (cfg_clk),
    .cfg_rst_n    (cfg_rst_n),
    .cfg_we       (cfg_we),
    .cfg_done     (cfg_done),
    .cfg_col_sel  (cfg_col_sel),
    .cfg_sclk_src (cfg_sclk_src),
    .cfg_sclk_pol (cfg_sclk_pol),
    .cfg_sr_src   (cfg_sr_src),
    .cfg_sr_inv   (cfg_sr_inv),
    .cfg_sr_set   (cfg_sr_set),
    .col_q        (col_q),
    .sect_q       (sect_q),
    .cfgd_q       (cfgd_q)
  );

  for (genvar c = 0; c < NCOLS; c++) begin : g_col
    localparam col_edge_e KIND = (c == 0) ? EDGE_LEFT :
                                 (c == NCOLS-1) ? EDGE_RIGHT : EDGE_NONE;
    logic [NFCLK-1:0] fsrc;

    if (KIND == EDGE_LEFT) begin : g_l
      assign fsrc = fclk[NFCLK-1:0];
    end else if (KIND == EDGE_RIGHT) begin : g_r
      assign fsrc = fclk[2*NFCLK-1:NFCLK];
    end else begin : g_n
      assign fsrc = '0;
    end

    colclk_col_mux #(.NGCLK(NGCLK), .NFCLK(NFCLK), .EDGE(KIND)) u_cmux (
      .gclk      (gclk),
      .fclk_edge (fsrc),
      .sel       (col_q[c]),
      .col_clk   (col_clk[c])
    );

    for (genvar s = 0; s < NSECT; s++) begin : g_sec
      localparam int I = c*NSECT + s;

      colclk_sect_clk u_sclk (
        .col_clk  (col_clk[c]),
        .loc_clk  (loc_clk[I]),
        .src_loc  (sect_q[I].sclk_src),
        .pol      (sect_q[I].sclk_pol),
        .cfgd     (cfgd_q),
        .sect_clk (sect_clk[I])
      );

      colclk_sect_sr u_ssr (
        .gsr_n    (gsr_n),
        .loc_sr_n (loc_sr_n[I]),
        .src_loc  (sect_q[I].sr_src),
        .inv      (sect_q[I].sr_inv),
        .to_set   (sect_q[I].sr_set),
        .cfgd     (cfgd_q),
        .set_n    (sect_set_n[I]),
        .rst_n    (sect_rst_n[I])
      );

      // R6
      sclk_off_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        (sect_q[I].sclk_pol == SPOL_OFF || sect_q[I].sclk_pol == SPOL_OFF3)
          |-> !sect_clk[I]);

      // R9
      sr_steer_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
        (cfgd_q && sect_q[I].sr_set) |-> sect_rst_n[I]);
    end
  end

  // R1
  unconf_force_chk: assert property (@(posedge cfg_clk) disable iff (!cfg_rst_n)
    !cfgd_q |-> (sect_clk == '0 && sect_set_n == '0 && (&sect_rst_n)));

endmodule

// File: tb/colclk_sel_top_bench.sv
module colclk_sel_top_bench;
  localparam int NCOLS = 4;
  localparam int NSECT = 2;
  localparam int NGCLK = 8;
  localparam int NFCLK = 2;
  localparam int NS = NCOLS * NSECT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0;
  logic done = 1'b0;
  logic [NCOLS*4-1:0] col_sel = '0;
  logic [NS-1:0] s_src = '0, sr_src = '0, sr_inv = '0, sr_set = '0;
  logic [2*NS-1:0] s_pol = '0;
  logic [NGCLK-1:0] gclk = '0;
  logic [2*NFCLK-1:0] fclk = '0;
  logic [NS-1:0] lclk = '0, lsr = '0;
  logic gsr = 1'b1;
  logic [NS-1:0] o_clk, o_set_n, o_rst_n;

  logic [NCOLS*4-1:0] a_col = '0;
  logic [NS-1:0] a_ssrc = '0, a_srsrc = '0, a_srinv = '0, a_srset = '0;
  logic [2*NS-1:0] a_pol = '0;
  logic exp_cfgd = 1'b0;

  int nchk = 0;
  int nerr = 0;
  logic [NS-1:0] alt;

  always #5 clk = ~clk;

  colclk_sel_top #(.NCOLS(NCOLS), .NSECT(NSECT), .NGCLK(NGCLK), .NFCLK(NFCLK)) u_colclk_sel_top (
    .cfg_clk(clk), .cfg_rst_n(rst_n), .cfg_we(we), .cfg_done(done),
    .cfg_col_sel(col_sel), .cfg_sclk_src(s_src), .cfg_sclk_pol(s_pol),
    .cfg_sr_src(sr_src), .cfg_sr_inv(sr_inv), .cfg_sr_set(sr_set),
    .gclk(gclk), .fclk(fclk), .loc_clk(lclk), .gsr_n(gsr), .loc_sr_n(lsr),
    .sect_clk(o_clk), .sect_set_n(o_set_n), .sect_rst_n(o_rst_n)
  );

  function automatic logic col_exp(int c, int code);
    if (code < NGCLK) return gclk[code];
    if (code < NGCLK + NFCLK && c == 0) return fclk[code-NGCLK];
    if (code < NGCLK + NFCLK && c == NCOLS-1) return fclk[NFCLK + code-NGCLK];
    return 1'b0;
  endfunction

  task automatic chk(string req, string what, int idx, logic act, logic exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s sector %0d: actual=%b expected=%b", req, what, idx, act, exp);
    end
  endtask

  task automatic check_all(string rc, string rs);
    for (int c = 0; c < NCOLS; c++) begin
      for (int s = 0; s < NSECT; s++) begin
        int i = c*NSECT + s;
        logic v, e_clk, e_set, e_rst, sv;
        v = a_ssrc[i] ? lclk[i] : col_exp(c, int'(a_col[c*4 +: 4]));
        case (a_pol[2*i +: 2])
          2'b01: e_clk = v;
          2'b10: e_clk = ~v;
          default: e_clk = 1'b0;
        endcase
        sv = (a_srsrc[i] ? lsr[i] : gsr) ^ a_srinv[i];
        e_set = a_srset[i] ? sv : 1'b1;
        e_rst = a_srset[i] ? 1'b1 : sv;
        if (!exp_cfgd) begin
          e_clk = 1'b0; e_set = 1'b0; e_rst = 1'b1;
        end
        chk(rc, "clk", i, o_clk[i], e_clk);
        chk(rs, "set_n", i, o_set_n[i], e_set);
        chk(rs, "rst_n", i, o_rst_n[i], e_rst);
      end
    end
  endtask

  task automatic apply_cfg();
    @(negedge clk);
    we = 1'b1;
    @(negedge clk);
    we = 1'b0;
    a_col = col_sel; a_ssrc = s_src; a_pol = s_pol;
    a_srsrc = sr_src; a_srinv = sr_inv; a_srset = sr_set;
    #1;
  endtask

  initial begin
    #2_000_000;
    nerr++;
    nchk++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) alt[i] = i[0];
    // R1: reset state with arbitrary inputs
    gclk = '1; lclk = '1; gsr = 1'b0; lsr = '0;
    col_sel = '0; s_src = '1; s_pol = {NS{2'b01}};
    #23;
    check_all("R1", "R1");
    rst_n = 1'b1;
    apply_cfg();
    check_all("R1", "R1");  // configured fields loaded but still unconfigured
    // R11: cfg_done starts configured state
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0; exp_cfgd = 1'b1; #1;
    check_all("R11", "R11");
    repeat (3) @(negedge clk);
    #1;
    check_all("R11", "R11");  // sticky after cfg_done drops

    // R2 R3 R4: column code sweep, one-hot and one-cold sources
    s_src = '0; s_pol = {NS{2'b01}}; sr_src = '0; sr_inv = '0; sr_set = '0; gsr = 1'b1;
    for (int code = 0; code < 16; code++) begin
      string tag;
      tag = (code < 8) ? "R2" : (code < 10) ? "R3" : "R4";
      col_sel = {NCOLS{4'(code)}};
      apply_cfg();
      for (int pat = 0; pat < 2; pat++) begin
        for (int t = 0; t < NGCLK + 2*NFCLK; t++) begin
          logic [NGCLK+2*NFCLK-1:0] v;
          v = '0; v[t] = 1'b1;
          if (pat == 1) v = ~v;
          gclk = v[NGCLK-1:0];
          fclk = v[NGCLK +: 2*NFCLK];
          #1;
          check_all(tag, "R12");
        end
      end
    end
    // R3: mixed per-column codes
    col_sel = {4'd9, 4'd5, 4'd3, 4'd8};
    apply_cfg();
    for (int p = 0; p < 8; p++) begin
      gclk = 8'(8'h5A ^ (p * 37));
      fclk = 4'(p ^ 4'hA);
      #1;
      check_all("R3", "R12");
    end

    // R5 R6: sector source and polarity sweep
    col_sel = '0;
    for (int src = 0; src < 2; src++) begin
      for (int pol = 0; pol < 4; pol++) begin
        s_src = {NS{src[0]}};
        s_pol = {NS{2'(pol)}};
        apply_cfg();
        for (int cv = 0; cv < 2; cv++) begin
          for (int lv = 0; lv < 2; lv++) begin
            gclk[0] = cv[0];
            lclk = lv[0] ? alt : ~alt;
            #1;
            check_all((pol == 1 || pol == 2) ? "R5" : "R6", "R12");
          end
        end
      end
    end

    // R7 R8 R9 R12: set/reset sweep, inputs changed between clock edges
    s_pol = {NS{2'b01}};
    for (int src = 0; src < 2; src++) begin
      for (int inv = 0; inv < 2; inv++) begin
        for (int md = 0; md < 2; md++) begin
          sr_src = {NS{src[0]}};
          sr_inv = {NS{inv[0]}};
          sr_set = {NS{md[0]}};
          apply_cfg();
          for (int gv = 0; gv < 2; gv++) begin
            for (int lv = 0; lv < 2; lv++) begin
              gsr = gv[0];
              lsr = lv[0] ? alt : ~alt;
              #1;
              check_all("R12", md ? "R9" : (inv ? "R8" : "R7"));
            end
          end
        end
      end
    end

    // Mixed per-sector configuration
    col_sel = {4'd8, 4'd7, 4'd2, 4'd9};
    for (int i = 0; i < NS; i++) begin
      s_src[i] = i[1];
      s_pol[2*i +: 2] = 2'(i);
      sr_src[i] = i[0];
      sr_inv[i] = i[1];
      sr_set[i] = i[2];
    end
    apply_cfg();
    for (int p = 0; p < 6; p++) begin
      gclk = 8'(p * 53 + 17); fclk = 4'(p * 5 + 3);
      lclk = 8'(p * 29 + 101); lsr = 8'(p * 71 + 9); gsr = p[0];
      #1;
      check_all("R5", "R7");
    end

    // R10: field changes without cfg_we are ignored
    col_sel = ~col_sel; s_src = ~s_src; s_pol = ~s_pol;
    sr_src = ~sr_src; sr_inv = ~sr_inv; sr_set = ~sr_set;
    repeat (3) @(negedge clk);
    for (int p = 0; p < 4; p++) begin
      gclk = 8'(p * 91 + 3); fclk = 4'(p + 6);
      lclk = 8'(p * 13 + 77); lsr = 8'(p * 41 + 5); gsr = ~p[0];
      #1;
      check_all("R10", "R10");
    end

    // R11: reset returns to forced outputs and clears fields
    @(negedge clk); rst_n = 1'b0; exp_cfgd = 1'b0;
    a_col = '0; a_ssrc = '0; a_pol = '0; a_srsrc = '0; a_srinv = '0; a_srset = '0;
    #1;
    check_all("R1", "R1");
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); done = 1'b1;
    @(negedge clk); done = 1'b0; exp_cfgd = 1'b1;
    gsr = 1'b0; gclk = '1; #1;
    check_all("R11", "R11");

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule